// File: doc/BRIEF.md
# Speed-Gated Direction Reversal Sequencer

This block sits in front of the commutation logic of a brushless motor drive. It decides when a requested change of rotation direction is allowed to reach the drivers. The direction request arrives asynchronously and passes through a synchronizer. It then meets a speed-qualified hold stage, which admits a new value only while a one-bit "motor is slow" qualifier is high. While the qualifier is low, the hold stage keeps the direction it already has, so a fast-spinning motor cannot be reversed into its power devices.

Past the hold stage, the direction walks through a chain of registers. The chain advances only on a single-cycle oscillator tick in the system clock domain. As a result, an effective reversal lags the hold stage by more than one and at most two oscillator periods. A registered inhibit flag blanks all drives while the synchronized request disagrees with the hold stage, or while the hold stage disagrees with the end of the chain. Blanking therefore covers both the coasting wait and the dead time. Every toggle of the synchronized request also raises a one-cycle tachometer request, whatever the speed.

Top module: `dir_rev_seq`

## Requirements
- R1: The hold stage copies the synchronized direction on a clock edge only when `slow_i` is 1 at that edge; when `slow_i` is 0 it keeps its value, so `dir_eff_o` never changes to a direction requested while the motor is fast.
- R2: The held direction passes through a chain of STAGES (default 2) registers, and `dir_eff_o` is the last stage of that chain.
- R3: After the hold stage changes, `dir_eff_o` follows between TP+1 and 2*TP clock cycles later, where TP is the tick period. With no ticks, `dir_eff_o` does not change.
- R4: `inhibit_o` is 1 in the cycle after either of two conditions holds, and 0 otherwise. The first condition is that the synchronized direction differs from the hold stage. The second is that the hold stage differs from the last chain stage.
- R5: Each change of the synchronized direction produces a `tach_req_o` pulse exactly one cycle wide, whatever the level of `slow_i`.
- R6: `dir_req_i` passes through a SYNC-flop synchronizer (default 2). A change applied between edges first shows on `tach_req_o` and `inhibit_o` after the third rising edge.
- R7: While `rst` is high, the synchronizer, hold stage and chain all load `dir_req_i`. `inhibit_o` and `tach_req_o` are held at 0.
- R8: `dir_eff_o` changes only on an edge at which `osc_tick_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_req_i | input | 1 | Asynchronous direction request |
| slow_i | input | 1 | Motor-slow qualifier; 1 lets a new direction in |
| osc_tick_i | input | 1 | One-cycle enable at the PWM oscillator rate |
| dir_eff_o | output | 1 | Effective direction for the commutation decoder |
| inhibit_o | output | 1 | Registered drive blanking flag |
| tach_req_o | output | 1 | One-cycle tachometer pulse request on a direction toggle |

## Verification
The bench reverses the direction at several tick phases and measures the delay to `dir_eff_o`. A chain that is one stage short or long, or that advances without a tick, lands outside the TP+1..2*TP window. It holds `slow_i` low across a toggle. A hold stage that is not gated would then let `dir_eff_o` flip, and a missing first comparison would drop the inhibit during the coasting wait. Toggling twice while fast checks two things: that the inhibit releases once request and hold agree again, and that both toggles are counted as tachometer pulses. It also checks that the inhibit never lapses between the hold-stage change and the end of the chain.

// File: rtl/drs_pkg.sv
package drs_pkg;
  localparam int DRS_SYNC_DEF   = 2;
  localparam int DRS_STAGES_DEF = 2;

  function automatic logic drs_differ(input logic a, input logic b);
    return a ^ b;
  endfunction
endpackage

// File: rtl/drs_sync.sv
module drs_sync #(
  parameter int SYNC = drs_pkg::DRS_SYNC_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [SYNC-1:0] ff_q;

  always_ff @(posedge clk) begin
    if (rst) ff_q <= {SYNC{d_i}};
    else     ff_q <= {ff_q[SYNC-2:0], d_i};
  end

  assign q_o = ff_q[SYNC-1];

  generate
    for (genvar i = 1; i < SYNC; i++) begin : g_chk
      p_sync_shift_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (ff_q[i] == $past(ff_q[i-1])));
    end
  endgenerate
endmodule

// File: rtl/drs_gate_hold.sv
module drs_gate_hold (
  input  logic clk,
  input  logic rst,
  input  logic rst_val_i,
  input  logic d_i,
  input  logic open_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= rst_val_i;
    else if (open_i) q_o <= d_i;
  end

  p_frozen_when_fast_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(open_i)) |-> $stable(q_o));
endmodule

// File: rtl/drs_tick_chain.sv
module drs_tick_chain #(
  parameter int STAGES = drs_pkg::DRS_STAGES_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_val_i,
  input  logic tick_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_st
      logic nxt;
      if (i == 0) begin : g_head
        assign nxt = d_i;
      end else begin : g_body
        assign nxt = st_q[i-1];
      end
      always_ff @(posedge clk) begin
        if (rst)         st_q[i] <= rst_val_i;
        else if (tick_i) st_q[i] <= nxt;
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];

  p_hold_without_tick_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick_i)) |-> $stable(q_o));
endmodule

// File: rtl/dir_rev_seq.sv
module dir_rev_seq #(
  parameter int SYNC   = drs_pkg::DRS_SYNC_DEF,
  parameter int STAGES = drs_pkg::DRS_STAGES_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic dir_req_i,
  input  logic slow_i,
  input  logic osc_tick_i,
  output logic dir_eff_o,
  output logic inhibit_o,
  output logic tach_req_o
);
  import drs_pkg::*;

  logic dir_s;
  logic dir_s_d;
  logic held_q;

  drs_sync #(.SYNC(SYNC)) u_sync (
    .clk (clk), .rst (rst), .d_i (dir_req_i), .q_o (dir_s)
  );

  drs_gate_hold u_hold (
    .clk (clk), .rst (rst), .rst_val_i (dir_req_i),
    .d_i (dir_s), .open_i (slow_i), .q_o (held_q)
  );

  drs_tick_chain #(.STAGES(STAGES)) u_chain (
    .clk (clk), .rst (rst), .rst_val_i (dir_req_i),
    .tick_i (osc_tick_i), .d_i (held_q), .q_o (dir_eff_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_s_d    <= dir_req_i;
      inhibit_o  <= 1'b0;
      tach_req_o <= 1'b0;
    end else begin
      dir_s_d    <= dir_s;
      inhibit_o  <= drs_differ(dir_s, held_q) | drs_differ(held_q, dir_eff_o);
      tach_req_o <= drs_differ(dir_s, dir_s_d);
    end
  end

  p_inhibit_on_hold_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (dir_s != held_q) |=> inhibit_o);

  p_eff_change_blanked_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(dir_eff_o)) |-> inhibit_o);

  p_tach_on_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (dir_s != dir_s_d)) |=> tach_req_o);
endmodule

// File: tb/sim_dir_rev_seq.sv
module sim_dir_rev_seq;
  localparam int TP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_req = 1'b1;
  logic slow = 1'b1;
  logic tick = 1'b0;
  logic tick_en = 1'b1;
  logic dir_eff, inhibit, tach;

  int total = 0;
  int bad = 0;
  int tach_cnt = 0;
  int tcnt = 0;

  always #2 clk = ~clk;

  dir_rev_seq u0 (
    .clk(clk), .rst(rst), .dir_req_i(dir_req), .slow_i(slow),
    .osc_tick_i(tick), .dir_eff_o(dir_eff), .inhibit_o(inhibit),
    .tach_req_o(tach)
  );

  always @(negedge clk) begin
    if (tach) tach_cnt++;
    if (tick_en) begin
      tcnt = (tcnt == TP - 1) ? 0 : tcnt + 1;
      tick = (tcnt == 0);
    end else begin
      tick = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R7 dir_eff after reset", dir_eff, 1);
    chk("R7 inhibit after reset", inhibit, 0);
    chk("R7 tach after reset", tach, 0);
  endtask

  task automatic t_reverse(input int offset);
    int t0 = -1;
    int t1 = -1;
    int gap = 0;
    int start_tach;
    logic old_eff;
    cyc(offset);
    slow = 1'b1;
    old_eff = dir_eff;
    start_tach = tach_cnt;
    dir_req = ~dir_req;
    for (int k = 1; k <= 4 * TP; k++) begin
      @(negedge clk);
      if (tach && t0 < 0) t0 = k;
      if (t0 >= 0 && t1 < 0 && !inhibit) gap++;
      if (t1 < 0 && dir_eff != old_eff) t1 = k;
    end
    chk("R6 sync latency to tach", t0, 3);
    chk("R5 one tach pulse per toggle", tach_cnt - start_tach, 1);
    chk("R2 R3 lag within window", (t1 - t0 >= TP + 1) && (t1 - t0 <= 2 * TP), 1);
    chk("R4 inhibit held through mismatch", gap, 0);
    chk("R4 inhibit released after settle", inhibit, 0);
  endtask

  task automatic t_fast_block;
    logic old_eff;
    int changed = 0;
    int start_tach;
    slow = 1'b0;
    old_eff = dir_eff;
    start_tach = tach_cnt;
    dir_req = ~dir_req;
    for (int k = 0; k < 6 * TP; k++) begin
      @(negedge clk);
      if (dir_eff != old_eff) changed++;
    end
    chk("R1 no change while fast", changed, 0);
    chk("R5 tach pulse while fast", tach_cnt - start_tach, 1);
    chk("R4 inhibit while hold frozen", inhibit, 1);
    slow = 1'b1;
    cyc(3 * TP);
    chk("R1 change admitted once slow", dir_eff, dir_req);
    chk("R4 inhibit drops after admit", inhibit, 0);
  endtask

  task automatic t_fast_double;
    logic old_eff;
    int start_tach;
    slow = 1'b0;
    old_eff = dir_eff;
    start_tach = tach_cnt;
    dir_req = ~dir_req;
    cyc(4);
    dir_req = ~dir_req;
    cyc(10);
    chk("R5 two toggles two pulses", tach_cnt - start_tach, 2);
    chk("R4 inhibit clears on match", inhibit, 0);
    chk("R1 direction kept", dir_eff, old_eff);
    slow = 1'b1;
  endtask

  task automatic t_no_tick;
    logic old_eff;
    tick_en = 1'b0;
    old_eff = dir_eff;
    dir_req = ~dir_req;
    cyc(5 * TP);
    chk("R8 no tick no change", dir_eff, old_eff);
    chk("R3 inhibit waits for tick", inhibit, 1);
    tick_en = 1'b1;
    cyc(3 * TP);
    chk("R3 change after ticks resume", dir_eff, dir_req);
    chk("R4 inhibit clear after resume", inhibit, 0);
  endtask

  initial begin
    cyc(4);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    for (int ph = 0; ph < 4; ph++) t_reverse(ph * 3 + 1);
    t_fast_block();
    t_fast_double();
    t_no_tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(20000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule